// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This core lets a host drive an I2C bus through a small word-addressed register set. A host write to the control register can open a transaction with a START, re-open it with a repeated START, or close it with a STOP. A host write to the data register shifts one byte onto the bus, MSB first, and captures the slave's acknowledge in the ninth clock. A single bit in the control register does two jobs: on a start command it picks START (0) or repeated START (1), and after a byte it reports the slave's answer (1 = NAK, 0 = ACK).

Every finished command or byte sets a sticky completion flag in the status register, which the host clears by writing 1 to it. SCL phase lengths come from a prescaler and a post-divider. START/STOP setup and hold lengths come from two small counts. Both lines are open-drain outputs: an output-enable of 1 pulls the line low. A pad-control bit can block all drive.

Register word addresses: 0 control, 1 timing, 2 counts, 3 data, 4 status, 5 pad control.

Top module: `i2cm_core`

## Requirements
- R1: After reset, control reads 0, status reads 0, pad control reads 4 (drive disabled), and both lines are released.
- R2: Writing control with enable (bit 0) set, command field (bits 2:1) equal to 1 and the qualifier (bit 3) clear produces a START: SDA falls while SCL is high, then SCL is pulled low.
- R3: A data-register write while enabled and idle sends bits 7:0 MSB first over eight SCL pulses. SDA changes only while SCL is low.
- R4: After a byte, control bit 3 reads 1 if the slave left SDA high in the ninth clock (NAK), and 0 if it pulled SDA low (ACK).
- R5: Completion of a START, repeated START, STOP or byte sets status bit 3. Writing 1 to status bit 3 clears it.
- R6: Command 1 with the qualifier set produces a repeated START from the held-low bus: SDA is released, SCL is released, then SDA falls while SCL is high.
- R7: Command 2 produces a STOP: SDA rises while SCL is high, and both lines end released.
- R8: While pad-control bit 2 is 1, neither line is driven low, even though commands still run and complete. Writing 0 enables drive.
- R9: Status bit 7 (busy) reads 1 from the cycle after a command or byte is accepted until it completes. Control and data writes made while busy are ignored.
- R10: Command 0, or any command with enable clear, causes no bus activity and no completion.
- R11: Each SCL high and low phase of a byte lasts (P+1)·D core cycles. P is timing bits 8:6. D is 1 when timing bit 2 is set, and otherwise timing bits 1:0 plus 2.
- R12: START/repeated START hold (SDA low to SCL low) lasts N+1 cycles, where N is counts bits 3:1. Repeated START setup (SCL high before SDA falls) lasts M+1 cycles, where M is counts bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | PRE_W+6 | Register write data |
| reg_rdata | output | PRE_W+6 | Register read data for reg_addr (combinational) |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The embedded assertions check on every cycle that SDA holds steady through each SCL high phase of a byte, and that SDA edges while SCL is high occur only in START hold or STOP. They also check that completion ends the busy window, that the completion flag is sticky until cleared, and that control writes during busy leave it unchanged. The bench's scenarios cover what needs a bus-level view. A bench slave decodes START, repeated START and STOP from the lines, collects transmitted bytes, and answers with ACK or NAK. Bench counters measure SCL phase, setup and hold lengths for two divider settings. On every clock, a model of the pad setting is compared with the line levels.

// File: rtl/i2cm_pkg.sv
// Package: shared operation codes and register word addresses of the I2C
// master core. Assumes a word-addressed register port of 3 address bits.
package i2cm_pkg;
    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_RESTART = 2'd1,
        OP_STOP    = 2'd2,
        OP_BYTE    = 2'd3
    } op_e;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_TIMING = 3'd1;
    localparam logic [2:0] RA_COUNTS = 3'd2;
    localparam logic [2:0] RA_DATA   = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;
    localparam logic [2:0] RA_PAD    = 3'd5;

    localparam logic [1:0] CMD_IDLE  = 2'd0;
    localparam logic [1:0] CMD_START = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;
endpackage

// File: rtl/i2cm_regs.sv
// Register file: decodes host writes into launch requests, keeps the
// control, timing, count, status and pad registers. Assumes the engine's
// busy and completion signals are synchronous to clk; writes are one-cycle.
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int M_W   = 4,
    parameter int N_W   = 3,
    localparam int REG_W = PRE_W + 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             nak_upd_i,
    input  logic             nak_i,
    output logic             go_o,
    output op_e              op_o,
    output logic [7:0]       byte_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             byp_o,
    output logic [1:0]       div_o,
    output logic [M_W-1:0]   m_o,
    output logic [N_W-1:0]   n_o,
    output logic             pad_off_o
);
    logic             en_q;
    logic [1:0]       cmd_q;
    logic             ack_q;
    logic             done_q;
    logic [REG_W-1:0] tim_q;
    logic [REG_W-1:0] cnt_q;
    logic             wr_ok;

    assign wr_ok  = reg_wr && !busy_i;
    assign byte_o = reg_wdata[7:0];
    assign pre_o  = tim_q[6 +: PRE_W];
    assign byp_o  = tim_q[2];
    assign div_o  = tim_q[1:0];
    assign m_o    = cnt_q[4 +: M_W];
    assign n_o    = cnt_q[1 +: N_W];

    // Launch decode: turns an accepted control or data write into an engine request.
    always_comb begin
        go_o = 1'b0;
        op_o = OP_START;
        if (wr_ok && reg_addr == RA_CTRL && reg_wdata[0]) begin
            if (reg_wdata[2:1] == CMD_START) begin
                go_o = 1'b1;
                op_o = reg_wdata[3] ? OP_RESTART : OP_START;
            end else if (reg_wdata[2:1] == CMD_STOP) begin
                go_o = 1'b1;
                op_o = OP_STOP;
            end
        end else if (wr_ok && reg_addr == RA_DATA && en_q) begin
            go_o = 1'b1;
            op_o = OP_BYTE;
        end
    end

    // Register update: host writes, ACK capture and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            cmd_q     <= CMD_IDLE;
            ack_q     <= 1'b0;
            done_q    <= 1'b0;
            tim_q     <= '0;
            cnt_q     <= '0;
            pad_off_o <= 1'b1;
        end else begin
            if (wr_ok && reg_addr == RA_CTRL) begin
                en_q  <= reg_wdata[0];
                cmd_q <= reg_wdata[2:1];
                ack_q <= reg_wdata[3];
            end else if (nak_upd_i) begin
                ack_q <= nak_i;
            end
            if (reg_wr && reg_addr == RA_TIMING) tim_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_COUNTS) cnt_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_PAD)    pad_off_o <= reg_wdata[2];
            if (done_i)
                done_q <= 1'b1;
            else if (reg_wr && reg_addr == RA_STATUS && reg_wdata[3])
                done_q <= 1'b0;
        end
    end

    // Read mux: returns the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata[3:0] = {ack_q, cmd_q, en_q};
            RA_TIMING: reg_rdata = tim_q;
            RA_COUNTS: reg_rdata = cnt_q;
            RA_STATUS: begin
                reg_rdata[7] = busy_i;
                reg_rdata[3] = done_q;
            end
            RA_PAD:    reg_rdata[2] = pad_off_o;
            default:   reg_rdata = '0;
        endcase
    end

    // R9: a control write made while busy leaves the control fields untouched.
    a_r9_ctrl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && reg_wr && reg_addr == RA_CTRL) |=> $stable({en_q, cmd_q}));
    // R5: completion always leaves the flag set.
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_q);
    // R5: write-one clears the flag when no completion coincides.
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_STATUS && reg_wdata[3] && !done_i) |=> !done_q);
endmodule

// File: rtl/i2cm_timing.sv
// Timing derivation: converts the prescale/divider fields and the M/N counts
// into reload values for the engine's phase timer. Purely combinational;
// assumes fields are changed only while the engine is idle.
module i2cm_timing #(
    parameter int PRE_W = 3,
    parameter int M_W   = 4,
    parameter int N_W   = 3,
    parameter int CNT_W = 8
) (
    input  logic [PRE_W-1:0] pre_i,
    input  logic             byp_i,
    input  logic [1:0]       div_i,
    input  logic [M_W-1:0]   m_i,
    input  logic [N_W-1:0]   n_i,
    output logic [CNT_W-1:0] half_ld_o,
    output logic [CNT_W-1:0] setup_ld_o,
    output logic [CNT_W-1:0] hold_ld_o
);
    logic [CNT_W-1:0] pre_ticks;
    logic [CNT_W-1:0] div_ticks;
    logic [CNT_W-1:0] product;

    // Phase length: (P+1) times the post-divider factor, stored as count-1.
    always_comb begin
        pre_ticks  = {{(CNT_W-PRE_W){1'b0}}, pre_i} + 1'b1;
        div_ticks  = byp_i ? CNT_W'(1) : ({{(CNT_W-2){1'b0}}, div_i} + CNT_W'(2));
        product    = pre_ticks * div_ticks;
        half_ld_o  = product - 1'b1;
        setup_ld_o = {{(CNT_W-M_W){1'b0}}, m_i};
        hold_ld_o  = {{(CNT_W-N_W){1'b0}}, n_i};
    end
endmodule

// File: rtl/i2cm_engine.sv
// Bit-level bus engine: sequences START, repeated START, STOP and 9-clock
// byte transfers with one down-counting phase timer. Assumes sda_i is
// synchronous to clk; outputs are registered "pull low" requests.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  op_e              op_i,
    input  logic [7:0]       byte_i,
    input  logic [CNT_W-1:0] half_ld_i,
    input  logic [CNT_W-1:0] setup_ld_i,
    input  logic [CNT_W-1:0] hold_ld_i,
    input  logic             sda_i,
    output logic             scl_lo_o,
    output logic             sda_lo_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             nak_upd_o,
    output logic             nak_o
);
    typedef enum logic [3:0] {
        PH_IDLE, PH_SU, PH_HD, PH_RS_LO, PH_RS_HI,
        PH_SP_LO, PH_SP_HI, PH_SP_REL, PH_BIT_LO, PH_BIT_HI
    } phase_e;

    phase_e           ph;
    op_e              cur_op;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;
    logic [3:0]       bitn;

    assign busy_o = (ph != PH_IDLE);

    // Phase sequencer: advances the bus phase when the timer expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            cur_op    <= OP_START;
            cnt       <= '0;
            shreg     <= '0;
            bitn      <= '0;
            scl_lo_o  <= 1'b0;
            sda_lo_o  <= 1'b0;
            done_o    <= 1'b0;
            nak_upd_o <= 1'b0;
            nak_o     <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            nak_upd_o <= 1'b0;
            if (ph == PH_IDLE) begin
                if (go_i) begin
                    cur_op <= op_i;
                    case (op_i)
                        OP_START: begin
                            ph <= PH_SU; scl_lo_o <= 1'b0; sda_lo_o <= 1'b0;
                            cnt <= setup_ld_i;
                        end
                        OP_RESTART: begin
                            ph <= PH_RS_LO; scl_lo_o <= 1'b1; sda_lo_o <= 1'b0;
                            cnt <= half_ld_i;
                        end
                        OP_STOP: begin
                            ph <= PH_SP_LO; scl_lo_o <= 1'b1; sda_lo_o <= 1'b1;
                            cnt <= half_ld_i;
                        end
                        default: begin
                            ph <= PH_BIT_LO; scl_lo_o <= 1'b1; sda_lo_o <= ~byte_i[7];
                            shreg <= byte_i; bitn <= '0; cnt <= half_ld_i;
                        end
                    endcase
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                case (ph)
                    PH_SU:     begin ph <= PH_HD; sda_lo_o <= 1'b1; cnt <= hold_ld_i; end
                    PH_HD:     begin ph <= PH_IDLE; scl_lo_o <= 1'b1; done_o <= 1'b1; end
                    PH_RS_LO:  begin ph <= PH_RS_HI; scl_lo_o <= 1'b0; cnt <= setup_ld_i; end
                    PH_RS_HI:  begin ph <= PH_HD; sda_lo_o <= 1'b1; cnt <= hold_ld_i; end
                    PH_SP_LO:  begin ph <= PH_SP_HI; scl_lo_o <= 1'b0; cnt <= setup_ld_i; end
                    PH_SP_HI:  begin ph <= PH_SP_REL; sda_lo_o <= 1'b0; cnt <= hold_ld_i; end
                    PH_SP_REL: begin ph <= PH_IDLE; done_o <= 1'b1; end
                    PH_BIT_LO: begin ph <= PH_BIT_HI; scl_lo_o <= 1'b0; cnt <= half_ld_i; end
                    PH_BIT_HI: begin
                        scl_lo_o <= 1'b1;
                        if (bitn == 4'd8) begin
                            ph        <= PH_IDLE;
                            sda_lo_o  <= 1'b0;
                            nak_o     <= sda_i;
                            nak_upd_o <= 1'b1;
                            done_o    <= 1'b1;
                        end else begin
                            ph    <= PH_BIT_LO;
                            cnt   <= half_ld_i;
                            bitn  <= bitn + 1'b1;
                            shreg <= {shreg[6:0], 1'b0};
                            sda_lo_o <= (bitn == 4'd7) ? 1'b0 : ~shreg[6];
                        end
                    end
                    default:   ph <= PH_IDLE;
                endcase
            end
        end
    end

    // R3: SDA request is held through every SCL high phase of a byte.
    a_r3_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_BIT_HI && $past(ph) == PH_BIT_HI) |-> $stable(sda_lo_o));
    // R2: SDA pulled low with SCL released happens only in START hold.
    a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_lo_o) && !scl_lo_o) |-> (ph == PH_HD));
    // R7: SDA released with SCL released happens only in a STOP.
    a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_lo_o) && !scl_lo_o) |-> (cur_op == OP_STOP));
    // R9: completion closes a busy window and lasts one cycle.
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/i2cm_core.sv
// Top level of the I2C master: register file, timing derivation and bus
// engine, with pad gating on the open-drain enables. Assumes a single
// master and no clock stretching.
module i2cm_core
    import i2cm_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int M_W   = 4,
    parameter int N_W   = 3,
    localparam int REG_W = PRE_W + 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int PROD_W = PRE_W + 3;
    localparam int CNT_W  = ((PROD_W > M_W) ? PROD_W : M_W) + 1;

    logic             go, busy, done, nak_upd, nak, pad_off, byp;
    logic             scl_lo, sda_lo;
    op_e              op;
    logic [7:0]       tx_byte;
    logic [PRE_W-1:0] pre;
    logic [1:0]       div;
    logic [M_W-1:0]   m_cnt;
    logic [N_W-1:0]   n_cnt;
    logic [CNT_W-1:0] half_ld, setup_ld, hold_ld;

    i2cm_regs #(.PRE_W(PRE_W), .M_W(M_W), .N_W(N_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
        .done_i(done), .nak_upd_i(nak_upd), .nak_i(nak), .go_o(go), .op_o(op),
        .byte_o(tx_byte), .pre_o(pre), .byp_o(byp), .div_o(div), .m_o(m_cnt),
        .n_o(n_cnt), .pad_off_o(pad_off)
    );

    i2cm_timing #(.PRE_W(PRE_W), .M_W(M_W), .N_W(N_W), .CNT_W(CNT_W)) u_timing (
        .pre_i(pre), .byp_i(byp), .div_i(div), .m_i(m_cnt), .n_i(n_cnt),
        .half_ld_o(half_ld), .setup_ld_o(setup_ld), .hold_ld_o(hold_ld)
    );

    i2cm_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go_i(go), .op_i(op), .byte_i(tx_byte),
        .half_ld_i(half_ld), .setup_ld_i(setup_ld), .hold_ld_i(hold_ld),
        .sda_i(sda_i), .scl_lo_o(scl_lo), .sda_lo_o(sda_lo), .busy_o(busy),
        .done_o(done), .nak_upd_o(nak_upd), .nak_o(nak)
    );

    assign scl_oe = scl_lo & ~pad_off;
    assign sda_oe = sda_lo & ~pad_off;
endmodule

// File: tb/test_i2cm_core.sv
module test_i2cm_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [8:0] reg_wdata = 9'd0;
    logic [8:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_drv = 1'b0;
    logic       slv_nak = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | slv_drv);

    int checks = 0, fails = 0;
    bit running = 1'b0;
    bit pad_model = 1'b1;

    always #10 clk = ~clk;

    i2cm_core i_i2cm_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bus monitor sampled between edges.
    int scl_hi_run = 0, hold_cnt = 0, hold_meas = 0, setup_meas = 0, last_high = 0;
    int starts = 0, stops = 0, scl_falls = 0;
    bit in_hold = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    always @(negedge clk) begin
        if (running) begin
            chk(!(pad_model && (!scl_line || !sda_line)), "R8 pad model", {scl_line, sda_line}, 3);
            if (p_sda && !sda_line && scl_line && p_scl) begin
                starts++; setup_meas = scl_hi_run; in_hold = 1'b1; hold_cnt = 0;
            end
            if (!p_sda && sda_line && scl_line && p_scl) stops++;
            if (in_hold && scl_line && !sda_line) hold_cnt++;
            if (p_scl && !scl_line) begin
                scl_falls++; last_high = scl_hi_run;
                if (in_hold) begin hold_meas = hold_cnt; in_hold = 1'b0; end
            end
            scl_hi_run = scl_line ? scl_hi_run + 1 : 0;
            p_scl = scl_line; p_sda = sda_line;
        end
    end

    // Bench slave: collects bytes and answers the ninth clock.
    int bitcnt = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] rxq[$];
    always @(negedge sda_line) if (scl_line) bitcnt = 0;
    always @(posedge scl_line) begin
        if (bitcnt < 8) sh = {sh[6:0], sda_line};
        bitcnt++;
    end
    always @(negedge scl_line) begin
        if (bitcnt == 8) slv_drv = ~slv_nak;
        else if (bitcnt == 9) begin slv_drv = 1'b0; bitcnt = 0; rxq.push_back(sh); end
    end

    task automatic wr(input logic [2:0] a, input logic [8:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        if (a == 3'd5) pad_model = d[2];
    endtask

    task automatic rd(input logic [2:0] a, output logic [8:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [8:0] s;
        int n = 0;
        do begin rd(3'd4, s); n++; end while (!s[3] && n < 5000);
        chk(s[3] && !s[7], req, int'(s), 8);
    endtask

    initial begin
        logic [8:0] v;
        int e0, s0, p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(3'd4, v); chk(v == 0, "R1 status", v, 0);
        rd(3'd5, v); chk(v == 4, "R1 pad", v, 4);
        chk(scl_line && sda_line, "R1 lines", {scl_line, sda_line}, 3);

        wr(3'd1, 9'h041);            // P=1, D=div 1+2 -> half 6
        wr(3'd2, 9'h034);            // M=3, N=2
        wr(3'd5, 9'h000);
        // R10: idle command and disabled start do nothing
        e0 = scl_falls; s0 = starts;
        wr(3'd0, 9'h001);
        wr(3'd0, 9'h002);
        repeat (40) @(negedge clk);
        rd(3'd4, v); chk(v == 0, "R10 no done", v, 0);
        chk(scl_falls == e0 && starts == s0, "R10 no activity", scl_falls - e0, 0);

        // R2 START, R9 busy
        wr(3'd0, 9'h003);
        rd(3'd4, v); chk(v[7] == 1, "R9 busy", v[7], 1);
        wait_done("R5 start done");
        chk(starts == s0 + 1, "R2 start seen", starts - s0, 1);
        chk(!scl_line && !sda_line, "R2 lines low", {scl_line, sda_line}, 0);
        chk(hold_meas == 3, "R12 hold", hold_meas, 3);
        wr(3'd4, 9'h008);
        rd(3'd4, v); chk(v == 0, "R5 w1c", v, 0);

        // R3/R4/R9/R11 byte with ACK, with ignored writes while busy
        slv_nak = 1'b0;
        wr(3'd3, 9'h0A5);
        wr(3'd3, 9'h03C);
        wr(3'd0, 9'h005);
        wait_done("R5 byte done");
        chk(rxq.size() == 1, "R9 data ignored", rxq.size(), 1);
        if (rxq.size() > 0) chk(rxq[0] == 8'hA5, "R3 byte", rxq[0], 8'hA5);
        rd(3'd0, v); chk(v[3] == 0, "R4 ack", v[3], 0);
        chk(v[2:1] == 1, "R9 ctrl ignored", v[2:1], 1);
        chk(last_high == 6, "R11 high len", last_high, 6);
        wr(3'd4, 9'h008);

        // R4 NAK
        slv_nak = 1'b1;
        wr(3'd3, 9'h05A);
        wait_done("R5 byte2 done");
        rd(3'd0, v); chk(v[3] == 1, "R4 nak", v[3], 1);
        chk(rxq.size() == 2 && rxq[1] == 8'h5A, "R3 byte2", rxq[rxq.size()-1], 8'h5A);
        wr(3'd4, 9'h008);

        // R6 repeated START, R12 setup
        s0 = starts;
        wr(3'd0, 9'h00B);
        wait_done("R5 restart done");
        chk(starts == s0 + 1, "R6 restart seen", starts - s0, 1);
        chk(setup_meas == 4, "R12 setup", setup_meas, 4);
        chk(hold_meas == 3, "R12 restart hold", hold_meas, 3);
        wr(3'd4, 9'h008);

        // R11 bypass timing: P=3, bypass -> 4
        wr(3'd1, 9'h0C4);
        slv_nak = 1'b0;
        wr(3'd0, 9'h001);            // clear qualifier, stay enabled
        wr(3'd3, 9'h081);
        wait_done("R5 byte3 done");
        chk(last_high == 4, "R11 bypass high len", last_high, 4);
        chk(rxq[rxq.size()-1] == 8'h81, "R3 byte3", rxq[rxq.size()-1], 8'h81);
        rd(3'd0, v); chk(v[3] == 0, "R4 ack3", v[3], 0);
        wr(3'd4, 9'h008);

        // R7 STOP
        p0 = stops;
        wr(3'd0, 9'h005);
        wait_done("R5 stop done");
        chk(stops == p0 + 1, "R7 stop seen", stops - p0, 1);
        chk(scl_line && sda_line, "R7 released", {scl_line, sda_line}, 3);
        wr(3'd4, 9'h008);

        // R8 pad drive disabled: commands complete, lines stay high
        wr(3'd5, 9'h004);
        e0 = scl_falls;
        wr(3'd0, 9'h003);
        wait_done("R8 start done");
        wr(3'd4, 9'h008);
        wr(3'd0, 9'h005);
        wait_done("R8 stop done");
        chk(scl_falls == e0, "R8 no edges", scl_falls - e0, 0);

        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule